// File: doc/BRIEF.md
# Paged Virtual Address Relocation Unit

This block turns a 16-bit virtual address into a physical address for a processor that keeps separate page tables per privilege mode. The virtual space is cut into eight 8 KB pages. Address bits [15:13] pick the page and bits [12:0] are the offset into it. Each page entry holds a relocation base, a length limit, an expand direction and two status flags. One flag records that the page was accessed and the other that it was written.

Translation is combinational. The physical address and a permit flag follow the access inputs within the same cycle. When an access breaks its page limit, a registered abort appears one cycle later, together with the abort vector and the captured faulting virtual address. Two control words are loaded through a plain write port, and so are the page bases and descriptors. The first control word switches relocation on or off. The second holds the per-mode data-space enables and the 22-bit enable. With relocation off, addresses stay 16 bits wide and the top virtual page is moved into the I/O region. With relocation on, the sum is cut to 18 or 22 bits, and any result that lands in the top physical page is forced into the I/O region.

Top module: `vpage_reloc`

## Requirements
- R1: With relocation off (control word 0 bit 0 clear), `phys_addr` equals the virtual address zero-extended, except that a virtual address with bits [15:13] = 7 gets bits [21:16] set to 0x3F. No abort is raised and no status flag changes.
- R2: With relocation on and 22-bit mode off, `phys_addr` = (offset + base*64) mod 2^18, where offset = virtual bits [12:0].
- R3: With relocation on and 22-bit mode on (control word 3 bit 4 set), `phys_addr` = (offset + base*64) mod 2^22.
- R4: A relocated result is ORed with 0x3C0000 when it has all top-page bits set. The top-page bits are mask 0x3E000 in 18-bit mode and 0x3C0000 in 22-bit mode.
- R5: For an expand-up page (descriptor bit 3 clear), the length field is descriptor bits [14:8]. The offset is permitted only when it is below length*64, so a length of 0 refuses every offset.
- R6: For an expand-down page (descriptor bit 3 set), the offset is permitted only when it is at least length*64. The offset can go up to 0x1FFF.
- R7: A permitted relocated access sets the entry's accessed flag, and a permitted write also sets its written flag. `hit_accessed`/`hit_written` show the flags of the entry the current inputs select. A descriptor write clears both flags.
- R8: A refused access drops `xlate_ok` in the same cycle. On the next cycle it raises `abort_o` with `abort_vec` = 0xA8 and `abort_va` holding the faulting virtual address. It leaves the status flags unchanged.
- R9: Modes 0 (kernel) and 1 (supervisor) each have their own instruction and data tables. Modes 2 and 3 share the user tables. A data access uses the data table only when its mode's enable is set in control word 3 (bit 0 user, bit 1 supervisor, bit 2 kernel). Otherwise it uses the instruction table.
- R10: A write to either control word takes effect for an access presented in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 control word 0, 1 control word 3, 2 page base, 3 page descriptor |
| cfg_idx | input | 6 | Entry select: [5:4] table (0 kernel, 1 supervisor, 2 user), [3] data space, [2:0] page |
| cfg_data | input | 16 | Write data |
| acc_valid | input | 1 | Access present |
| acc_va | input | 16 | Virtual address |
| acc_mode | input | 2 | Processor mode |
| acc_dspace | input | 1 | Data-space access |
| acc_write | input | 1 | Write access |
| phys_addr | output | 22 | Translated physical address |
| xlate_ok | output | 1 | Access valid and permitted |
| hit_accessed | output | 1 | Accessed flag of selected entry |
| hit_written | output | 1 | Written flag of selected entry |
| abort_o | output | 1 | Registered abort for previous cycle's access |
| abort_vec | output | 8 | Abort vector |
| abort_va | output | 16 | Captured faulting virtual address |

## Verification
Directed accesses cover several address ranges. Top-page addresses with relocation off show whether the I/O lift happens. A base that carries past bit 17 shows the difference between 18-bit and 22-bit truncation. Bases landing at the top of each width show whether I/O forcing is applied in one width and left out in the other. Offsets one below and at the limit, in both expand directions and with a zero length, locate the off-by-one edges. Read, write and descriptor-rewrite sequences show how the flags behave, and a refused access shows that it leaves them alone. Alternating data-space enables and modes across tables with distinct bases show which table was chosen. Random tables and accesses then mix all of these.

// File: rtl/vpr_pkg.sv
package vpr_pkg;
  localparam int VA_W    = 16;
  localparam int PG_W    = 3;
  localparam int OFF_W   = VA_W - PG_W;
  localparam int PA_W    = 22;
  localparam int NARROW  = 18;
  localparam int BASE_W  = 16;
  localparam int LEN_W   = 7;
  localparam int BLK_SH  = 6;
  localparam int N_TBL   = 3;
  localparam int IDX_W   = 2 + 1 + PG_W;
  localparam int N_ENT   = N_TBL * 2 * (1 << PG_W);
  localparam logic [PA_W-1:0] IO_OR    = 22'h3C0000;
  localparam logic [PA_W-1:0] TOP_NAR  = 22'h03E000;
  localparam logic [PA_W-1:0] TOP_WIDE = 22'h3C0000;

  typedef enum logic [1:0] {
    CFG_CTL0 = 2'd0,
    CFG_CTL3 = 2'd1,
    CFG_BASE = 2'd2,
    CFG_DESC = 2'd3
  } cfg_kind_e;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [LEN_W-1:0]  len;
    logic              down;
  } page_desc_t;

  function automatic logic [1:0] table_of_mode(input logic [1:0] m);
    case (m)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic limit_breach(input logic [OFF_W-1:0] off,
                                        input logic [LEN_W-1:0] len,
                                        input logic down);
    logic [OFF_W-1:0] lim;
    lim = {len, {BLK_SH{1'b0}}};
    return down ? (off < lim) : (off >= lim);
  endfunction

  function automatic logic [PA_W-1:0] relocate(input logic [OFF_W-1:0] off,
                                               input logic [BASE_W-1:0] base,
                                               input logic wide);
    logic [PA_W-1:0] s;
    s = {{(PA_W-OFF_W){1'b0}}, off} + {base, {BLK_SH{1'b0}}};
    return wide ? s : {{(PA_W-NARROW){1'b0}}, s[NARROW-1:0]};
  endfunction

  function automatic logic [PA_W-1:0] top_page_bits(input logic wide);
    return wide ? TOP_WIDE : TOP_NAR;
  endfunction
endpackage

// File: rtl/vpr_table.sv
module vpr_table
  import vpr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_kind,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [15:0]      cfg_data,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             upd_en,
  input  logic             upd_wr,
  output page_desc_t       rd_desc,
  output logic             rd_acc,
  output logic             rd_wr
);
  page_desc_t desc_q [N_ENT];
  logic       acc_q  [N_ENT];
  logic       wr_q   [N_ENT];

  logic base_we, desc_we;
  assign base_we = cfg_we && (cfg_kind == CFG_BASE);
  assign desc_we = cfg_we && (cfg_kind == CFG_DESC);

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic sel_cfg, sel_upd;
    assign sel_cfg = (cfg_idx == IDX_W'(e));
    assign sel_upd = upd_en && (rd_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        desc_q[e] <= '0;
        acc_q[e]  <= 1'b0;
        wr_q[e]   <= 1'b0;
      end else begin
        if (base_we && sel_cfg) desc_q[e].base <= cfg_data;
        if (desc_we && sel_cfg) begin
          desc_q[e].len  <= cfg_data[14:8];
          desc_q[e].down <= cfg_data[3];
          acc_q[e]       <= 1'b0;
          wr_q[e]        <= 1'b0;
        end else if (sel_upd) begin
          acc_q[e] <= 1'b1;
          if (upd_wr) wr_q[e] <= 1'b1;
        end
      end
    end
  end

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_data[15], cfg_data[7:4], cfg_data[2:0]};

  always_comb begin
    if (rd_idx < IDX_W'(N_ENT)) begin
      rd_desc = desc_q[rd_idx];
      rd_acc  = acc_q[rd_idx];
      rd_wr   = wr_q[rd_idx];
    end else begin
      rd_desc = '0;
      rd_acc  = 1'b0;
      rd_wr   = 1'b0;
    end
  end

  // R7: written never stands without accessed
  p_wr_needs_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wr |-> rd_acc);
  // R7: a permitted access marks its entry at the next edge
  p_mark_after_use_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !cfg_we) |=> acc_q[$past(rd_idx)]);
  // R7: descriptor rewrite clears the written flag
  p_desc_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_we && !upd_en) |=> !wr_q[$past(cfg_idx)]);
endmodule

// File: rtl/vpr_bound.sv
module vpr_bound
  import vpr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFF_W-1:0] off,
  input  page_desc_t       desc,
  output logic             breach
);
  assign breach = limit_breach(off, desc.len, desc.down);

  // R5: offset zero is inside any non-empty expand-up page
  p_up_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!desc.down && desc.len != '0 && off == '0) |-> !breach);
  // R5: empty expand-up page refuses everything
  p_up_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!desc.down && desc.len == '0) |-> breach);
  // R6: last offset is inside every expand-down page
  p_down_ceiling_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (desc.down && off == '1) |-> !breach);
endmodule

// File: rtl/vpr_adder.sv
module vpr_adder
  import vpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mm_en,
  input  logic              wide,
  input  logic [VA_W-1:0]   va,
  input  logic [BASE_W-1:0] base,
  output logic [PA_W-1:0]   pa,
  output logic              io_hit
);
  logic [PA_W-1:0] raw, hip;

  always_comb begin
    raw    = relocate(va[OFF_W-1:0], base, wide);
    hip    = top_page_bits(wide);
    io_hit = mm_en && ((raw & hip) == hip);
    if (!mm_en) begin
      pa = (va[VA_W-1 -: PG_W] == '1) ? ({{(PA_W-VA_W){1'b0}}, va} | {6'h3F, 16'h0})
                                      : {{(PA_W-VA_W){1'b0}}, va};
    end else begin
      pa = io_hit ? (raw | IO_OR) : raw;
    end
  end

  // R4: forced results sit in the I/O region
  p_io_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> (pa[PA_W-1 -: 4] == 4'hF));
  // R1: unrelocated results carry either no upper bits or all of them
  p_plain_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mm_en |-> (pa[PA_W-1:VA_W] == '0 || pa[PA_W-1:VA_W] == '1));
  // R2: narrow relocation outside the top page stays within 18 bits
  p_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_en && !wide && !io_hit) |-> (pa[PA_W-1:NARROW] == '0));
endmodule

// File: rtl/vpage_reloc.sv
module vpage_reloc
  import vpr_pkg::*;
#(
  parameter logic [7:0] ABORT_VEC = 8'hA8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_kind,
  input  logic [5:0]  cfg_idx,
  input  logic [15:0] cfg_data,
  input  logic        acc_valid,
  input  logic [15:0] acc_va,
  input  logic [1:0]  acc_mode,
  input  logic        acc_dspace,
  input  logic        acc_write,
  output logic [21:0] phys_addr,
  output logic        xlate_ok,
  output logic        hit_accessed,
  output logic        hit_written,
  output logic        abort_o,
  output logic [7:0]  abort_vec,
  output logic [15:0] abort_va
);
  logic       mm_en_q, wide_q;
  logic [2:0] ds_en_q;   // [0] user, [1] supervisor, [2] kernel

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mm_en_q <= 1'b0;
      wide_q  <= 1'b0;
      ds_en_q <= '0;
    end else if (cfg_we) begin
      if (cfg_kind == CFG_CTL0) mm_en_q <= cfg_data[0];
      if (cfg_kind == CFG_CTL3) begin
        ds_en_q <= cfg_data[2:0];
        wide_q  <= cfg_data[4];
      end
    end
  end

  logic [1:0]       tbl;
  logic             ds_allowed, use_d;
  logic [IDX_W-1:0] sel_idx;

  always_comb begin
    tbl = table_of_mode(acc_mode);
    case (tbl)
      2'd0:    ds_allowed = ds_en_q[2];
      2'd1:    ds_allowed = ds_en_q[1];
      default: ds_allowed = ds_en_q[0];
    endcase
    use_d   = acc_dspace && ds_allowed;
    sel_idx = {tbl, use_d, acc_va[VA_W-1 -: PG_W]};
  end

  page_desc_t ent;
  logic       breach, io_hit, refuse, upd_en;

  assign refuse = acc_valid && mm_en_q && breach;
  assign upd_en = acc_valid && mm_en_q && !breach;

  vpr_table u_table (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .rd_idx(sel_idx), .upd_en(upd_en), .upd_wr(acc_write),
    .rd_desc(ent), .rd_acc(hit_accessed), .rd_wr(hit_written)
  );

  vpr_bound u_bound (
    .clk(clk), .rst_n(rst_n),
    .off(acc_va[OFF_W-1:0]), .desc(ent), .breach(breach)
  );

  vpr_adder u_adder (
    .clk(clk), .rst_n(rst_n),
    .mm_en(mm_en_q), .wide(wide_q), .va(acc_va), .base(ent.base),
    .pa(phys_addr), .io_hit(io_hit)
  );

  assign xlate_ok  = acc_valid && !refuse;
  assign abort_vec = ABORT_VEC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_o  <= 1'b0;
      abort_va <= '0;
    end else begin
      abort_o <= refuse;
      if (refuse) abort_va <= acc_va;
    end
  end

  // R8: a refused access is followed by the abort
  p_abort_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> abort_o);
  // R8: captured address belongs to the refused access
  p_abort_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (abort_va == $past(acc_va)));
  // R1: no abort can follow an unrelocated access
  p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !mm_en_q) |=> !abort_o);
  // R4: forcing only happens with relocation on
  p_io_only_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> mm_en_q);
endmodule

// File: tb/test_vpage_reloc.sv
`timescale 1ns/100ps
module test_vpage_reloc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [5:0]  cfg_idx = '0;
  logic [15:0] cfg_data = '0;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_va = '0;
  logic [1:0]  acc_mode = '0;
  logic        acc_dspace = 1'b0;
  logic        acc_write = 1'b0;
  logic [21:0] phys_addr;
  logic        xlate_ok, hit_accessed, hit_written, abort_o;
  logic [7:0]  abort_vec;
  logic [15:0] abort_va;

  always #2.5 clk = ~clk;

  vpage_reloc i_vpage_reloc (.*);

  int total = 0, bad = 0;
  bit done = 0;

  int unsigned base_m [48];
  int unsigned len_m  [48];
  bit dn_m [48], a_m [48], w_m [48];
  bit en_m = 0, wide_m = 0;
  bit ds_m [3];   // by table: 0 kernel, 1 supervisor, 2 user

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int kind, input int idx, input int unsigned data);
    @(negedge clk);
    cfg_we = 1; cfg_kind = 2'(kind); cfg_idx = 6'(idx); cfg_data = 16'(data);
    @(negedge clk);
    cfg_we = 0;
    case (kind)
      0: en_m = data[0];
      1: begin ds_m[2] = data[0]; ds_m[1] = data[1]; ds_m[0] = data[2]; wide_m = data[4]; end
      2: if (idx < 48) base_m[idx] = data & 16'hFFFF;
      default: if (idx < 48) begin
        len_m[idx] = (data >> 8) & 7'h7F; dn_m[idx] = data[3]; a_m[idx] = 0; w_m[idx] = 0;
      end
    endcase
  endtask

  function automatic int desc_word(input int len, input bit down);
    return (len << 8) | (down ? 8 : 0);
  endfunction

  task automatic access(input int unsigned va, input int mode, input bit ds, input bit wr,
                        input string tag);
    int ti, ent;
    int unsigned off, lim, s, pa;
    bit viol, io;
    ti  = (mode == 0) ? 0 : (mode == 1) ? 1 : 2;
    ent = ti * 16 + ((ds && ds_m[ti]) ? 8 : 0) + (va / 8192);
    viol = 0;
    if (!en_m) begin
      pa = (va >= 32'hE000) ? va + 32'h3F0000 : va;
    end else begin
      off = va % 8192;
      lim = len_m[ent] * 64;
      viol = dn_m[ent] ? (off < lim) : (off >= lim);
      s = off + base_m[ent] * 64;
      s = wide_m ? s % (1 << 22) : s % (1 << 18);
      io = wide_m ? (s >= 32'h3C0000) : (s >= 32'h3E000);
      pa = io ? (s | 32'h3C0000) : s;
    end
    @(negedge clk);
    acc_valid = 1; acc_va = 16'(va); acc_mode = 2'(mode); acc_dspace = ds; acc_write = wr;
    #1;
    if (!viol) chk(phys_addr == 22'(pa), {tag, " addr"}, phys_addr, pa);
    chk(xlate_ok == !viol, {tag, " ok R8"}, xlate_ok, !viol);
    chk(hit_accessed == a_m[ent], {tag, " acc R7"}, hit_accessed, a_m[ent]);
    chk(hit_written == w_m[ent], {tag, " wr R7"}, hit_written, w_m[ent]);
    @(negedge clk);
    acc_valid = 0;
    chk(abort_o == viol, {tag, " abort R8"}, abort_o, viol);
    if (viol) begin
      chk(abort_va == 16'(va), {tag, " abort_va R8"}, abort_va, va);
      chk(abort_vec == 8'hA8, {tag, " vec R8"}, abort_vec, 8'hA8);
    end
    if (en_m && !viol) begin
      a_m[ent] = 1;
      if (wr) w_m[ent] = 1;
    end
  endtask

  initial begin
    #900000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    foreach (base_m[i]) begin base_m[i] = 0; len_m[i] = 0; dn_m[i] = 0; a_m[i] = 0; w_m[i] = 0; end
    foreach (ds_m[i]) ds_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(abort_o == 0, "reset abort R8", abort_o, 0);
    chk(hit_accessed == 0 && hit_written == 0, "reset flags R7", {hit_accessed, hit_written}, 0);

    // R1 relocation off
    access(16'h1234, 0, 0, 0, "R1 low page");
    access(16'hE010, 0, 0, 1, "R1 top page");
    access(16'hFFFE, 3, 1, 0, "R1 top end");

    // R10 control takes effect next cycle; R2 narrow relocation
    cfg(3, 0, desc_word(127, 0));
    cfg(2, 0, 16'h0200);
    cfg(0, 0, 1);
    access(16'h0100, 0, 0, 0, "R10 R2 first");
    access(16'h0104, 0, 0, 1, "R7 write");
    access(16'h0108, 0, 0, 0, "R7 after write");
    cfg(3, 0, desc_word(127, 0));
    access(16'h0108, 0, 0, 0, "R7 cleared");

    // R2 / R3 width
    cfg(3, 1, desc_word(127, 0));
    cfg(2, 1, 16'h1000);
    access(16'h2010, 0, 0, 0, "R2 wrap 18");
    cfg(1, 0, 16'h0010);
    access(16'h2010, 0, 0, 0, "R3 wide");

    // R4 I/O forcing
    cfg(3, 2, desc_word(127, 0));
    cfg(2, 2, 16'h0F80);
    access(16'h4004, 0, 0, 0, "R4 wide no force");
    cfg(1, 0, 16'h0000);
    access(16'h4004, 0, 0, 0, "R4 narrow force");
    cfg(2, 2, 16'hF000);
    cfg(1, 0, 16'h0010);
    access(16'h4004, 0, 0, 0, "R4 wide top");
    cfg(1, 0, 16'h0000);

    // R5 expand-up limits
    cfg(3, 3, desc_word(4, 0));
    cfg(2, 3, 16'h0040);
    access(16'h60FF, 0, 0, 0, "R5 below limit");
    access(16'h6100, 0, 0, 1, "R5 at limit");
    access(16'h60FF, 0, 0, 0, "R5 R8 no mark on refuse");
    cfg(3, 3, desc_word(0, 0));
    access(16'h6000, 0, 0, 0, "R5 empty");

    // R6 expand-down limits
    cfg(3, 4, desc_word(4, 1));
    access(16'h80FF, 0, 0, 0, "R6 below limit");
    access(16'h8100, 0, 0, 0, "R6 at limit");
    access(16'h9FFF, 0, 0, 1, "R6 top");

    // R9 table selection
    cfg(3, 32, desc_word(127, 0)); cfg(2, 32, 16'h0300);
    cfg(3, 40, desc_word(127, 0)); cfg(2, 40, 16'h0500);
    cfg(3, 16, desc_word(127, 0)); cfg(2, 16, 16'h0700);
    cfg(3, 24, desc_word(127, 0)); cfg(2, 24, 16'h0900);
    access(16'h0010, 3, 1, 0, "R9 user data disabled");
    cfg(1, 0, 16'h0001);
    access(16'h0010, 3, 1, 0, "R9 user data enabled");
    access(16'h0010, 2, 0, 0, "R9 mode2 instr");
    access(16'h0010, 1, 1, 0, "R9 super data disabled");
    cfg(1, 0, 16'h0002);
    access(16'h0010, 1, 1, 0, "R9 super data enabled");
    access(16'h0010, 3, 1, 0, "R9 user back to instr");

    // random mix
    for (int e = 0; e < 48; e++) begin
      cfg(2, e, $urandom & 16'hFFFF);
      cfg(3, e, desc_word($urandom % 128, $urandom % 2));
    end
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) begin
        cfg(1, 0, $urandom & 16'h0017);
        cfg(0, 0, (n % 200 == 150) ? 0 : 1);
      end
      access($urandom & 16'hFFFF, $urandom % 4, $urandom % 2, $urandom % 2, "R2 R3 R4 R5 R6 R9 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule